// File: doc/BRIEF.md
# Tagged Request Arbiter with Response Router

This block lets several requesters share one downstream request channel. Each cycle it picks at most one input with a pending request, either by strict fixed priority or by a rotating pointer; a parameter chooses the policy. The chosen request goes out with the index of its source port appended below its original tag bits. It passes through an elastic pipeline of parameterised depth, so it leaves the block a set number of cycles after acceptance.

Responses come back on a single channel and carry the extended tag. The block reads the source index from the low tag bits, removes those bits, and presents the response on the matching per-port response output one cycle after accepting it. Because the index travels inside the tag, no table of outstanding requests is kept. With a single input port the block is plain wiring in both directions.

Top module: `tag_xbar`

## Requirements
- R1: With N ports the tag grows by E = ceil(log2 N) bits. A forwarded request's tag is {incoming tag, granted port index}, with the index in bits [E-1:0]. Its data is unchanged.
- R2: A response is steered to the port whose number equals tag bits [E-1:0]. That port sees tag bits [E+TAG_W-1:E]. If the index names no existing port, the response is dropped one cycle after acceptance and no port output goes valid.
- R3: In any cycle at most one request ready is high, and only for an input whose valid is high.
- R4: In rotating mode the search starts at a cursor, wraps modulo N, and the first valid input wins. After each grant the cursor becomes (winner+1) mod N.
- R5: In fixed mode the lowest-numbered valid input always wins, including when the same inputs stay valid over consecutive cycles.
- R6: When the output is never stalled, a request granted in cycle c is presented on the output in cycle c+REQ_LAT, and requests leave in grant order. REQ_LAT is at least 1.
- R7: While the output is valid and not ready, the output valid, tag and data stay unchanged. Requests held back by a stall are neither lost nor reordered.
- R8: An accepted response appears on its port output in the next cycle and stays there until that port is ready. The response input is ready only when nothing is held or the held response leaves in this cycle.
- R9: With N = 1 both directions are combinational wires. Tags pass through unmodified, and each ready follows the opposite side's ready.
- R10: After reset no output is valid, and the rotating cursor starts at port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | NUM_PORTS | Per-port request valid |
| req_ready_o | output | NUM_PORTS | Per-port request accepted |
| req_tag_i | input | NUM_PORTS*TAG_W | Per-port request tag, port p at [p*TAG_W +: TAG_W] |
| req_data_i | input | NUM_PORTS*DATA_W | Per-port request payload |
| fwd_valid_o | output | 1 | Forwarded request valid |
| fwd_ready_i | input | 1 | Downstream accepts forwarded request |
| fwd_tag_o | output | TAG_W+E | Extended request tag |
| fwd_data_o | output | DATA_W | Forwarded payload |
| ret_valid_i | input | 1 | Response valid |
| ret_ready_o | output | 1 | Response accepted |
| ret_tag_i | input | TAG_W+E | Response tag carrying the port index |
| ret_data_i | input | DATA_W | Response payload |
| back_valid_o | output | NUM_PORTS | Per-port response valid |
| back_ready_i | input | NUM_PORTS | Per-port response ready |
| back_tag_o | output | TAG_W | Stripped response tag, shared by all ports |
| back_data_o | output | DATA_W | Response payload, shared by all ports |

## Verification
The hold properties on the forwarded and returned outputs make no demand on the inputs. The grant properties also hold whatever the requesters do. The block does assume that a requester keeps its valid, tag and data steady until they are accepted, because it reads them again in the accepting cycle. The stimulus therefore reloads a source only after its handshake. It changes the downstream and per-port ready lines freely, and response tags may name any port, including one that does not exist in the three-port build.

// File: rtl/tag_xbar_pkg.sv
package tag_xbar_pkg;

  typedef enum logic {
    ARB_FIXED  = 1'b0,
    ARB_ROTATE = 1'b1
  } arb_mode_e;

  function automatic int ext_width(input int n);
    return (n > 1) ? $clog2(n) : 0;
  endfunction

endpackage

// File: rtl/tag_xbar_arb.sv
module tag_xbar_arb
  import tag_xbar_pkg::*;
#(
  parameter int        NUM_PORTS = 4,
  parameter int        IDX_W     = 2,
  parameter arb_mode_e MODE      = ARB_ROTATE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] req,
  input  logic                 take,
  output logic [NUM_PORTS-1:0] gnt,
  output logic [IDX_W-1:0]     gnt_idx,
  output logic                 gnt_any
);

  logic [IDX_W-1:0] cursor;
  logic [IDX_W-1:0] win_idx;
  logic             win_any;

  // search from the cursor, wrapping modulo the port count
  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (!win_any && req[(int'(cursor) + i) % NUM_PORTS]) begin
        win_any = 1'b1;
        win_idx = IDX_W'((int'(cursor) + i) % NUM_PORTS);
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      gnt[p] = win_any && (win_idx == IDX_W'(p));
    end
  end

  assign gnt_idx = win_idx;
  assign gnt_any = win_any;

  generate
    if (MODE == ARB_ROTATE) begin : g_rotate
      logic [IDX_W-1:0] cur_q;
      logic [IDX_W-1:0] cur_d;

      always_comb begin
        cur_d = cur_q;
        if (take && win_any) begin
          if (int'(win_idx) == NUM_PORTS - 1) begin
            cur_d = '0;
          end else begin
            cur_d = win_idx + 1'b1;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cur_q <= '0;
        end else begin
          cur_q <= cur_d;
        end
      end

      assign cursor = cur_q;
    end else begin : g_fixed
      assign cursor = '0;
    end
  endgenerate

endmodule

// File: rtl/tag_xbar_pipe.sv
module tag_xbar_pipe #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_payload,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_payload
);

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] vld_d;
  logic [DEPTH-1:0] load;
  logic [DEPTH:0]   rdy_chain;
  logic [WIDTH-1:0] dat_q   [DEPTH];
  logic [WIDTH-1:0] src_dat [DEPTH];
  logic [DEPTH-1:0] src_vld;

  // a stage may take new contents when empty or when its own contents move on
  always_comb begin
    rdy_chain[DEPTH] = out_ready;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      rdy_chain[i] = !vld_q[i] || rdy_chain[i+1];
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 0) begin
        src_vld[i] = in_valid;
        src_dat[i] = in_payload;
      end else begin
        src_vld[i] = vld_q[i-1];
        src_dat[i] = dat_q[i-1];
      end
      load[i]  = rdy_chain[i] && src_vld[i];
      vld_d[i] = rdy_chain[i] ? src_vld[i] : vld_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (load[i]) begin
        dat_q[i] <= src_dat[i];
      end
    end
  end

  assign in_ready    = rdy_chain[0];
  assign out_valid   = vld_q[DEPTH-1];
  assign out_payload = dat_q[DEPTH-1];

endmodule

// File: rtl/tag_xbar_rsp.sv
module tag_xbar_rsp #(
  parameter int NUM_PORTS = 4,
  parameter int TAG_W     = 8,
  parameter int EXT_W     = 2,
  parameter int DATA_W    = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ret_valid_i,
  output logic                   ret_ready_o,
  input  logic [TAG_W+EXT_W-1:0] ret_tag_i,
  input  logic [DATA_W-1:0]      ret_data_i,
  output logic [NUM_PORTS-1:0]   back_valid_o,
  input  logic [NUM_PORTS-1:0]   back_ready_i,
  output logic [TAG_W-1:0]       back_tag_o,
  output logic [DATA_W-1:0]      back_data_o
);

  logic              hold_q;
  logic              hold_d;
  logic [EXT_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] dat_q;
  logic              dst_ready;
  logic              leave;
  logic              accept;

  // an index with no port behind it reads as ready, so it is dropped
  always_comb begin
    dst_ready = 1'b1;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (idx_q == EXT_W'(p)) begin
        dst_ready = back_ready_i[p];
      end
    end
  end

  assign leave       = hold_q && dst_ready;
  assign ret_ready_o = !hold_q || leave;
  assign accept      = ret_valid_i && ret_ready_o;

  always_comb begin
    hold_d = hold_q;
    if (accept) begin
      hold_d = 1'b1;
    end else if (leave) begin
      hold_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      idx_q <= ret_tag_i[EXT_W-1:0];
      tag_q <= ret_tag_i[TAG_W+EXT_W-1:EXT_W];
      dat_q <= ret_data_i;
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      back_valid_o[p] = hold_q && (idx_q == EXT_W'(p));
    end
  end

  assign back_tag_o  = tag_q;
  assign back_data_o = dat_q;

endmodule

// File: rtl/tag_xbar.sv
module tag_xbar
  import tag_xbar_pkg::*;
#(
  parameter int        NUM_PORTS = 4,
  parameter int        TAG_W     = 8,
  parameter int        DATA_W    = 16,
  parameter int        REQ_LAT   = 2,
  parameter arb_mode_e ARB_MODE  = ARB_ROTATE
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic [NUM_PORTS-1:0]                          req_valid_i,
  output logic [NUM_PORTS-1:0]                          req_ready_o,
  input  logic [NUM_PORTS*TAG_W-1:0]                    req_tag_i,
  input  logic [NUM_PORTS*DATA_W-1:0]                   req_data_i,
  output logic                                          fwd_valid_o,
  input  logic                                          fwd_ready_i,
  output logic [TAG_W+tag_xbar_pkg::ext_width(NUM_PORTS)-1:0] fwd_tag_o,
  output logic [DATA_W-1:0]                             fwd_data_o,
  input  logic                                          ret_valid_i,
  output logic                                          ret_ready_o,
  input  logic [TAG_W+tag_xbar_pkg::ext_width(NUM_PORTS)-1:0] ret_tag_i,
  input  logic [DATA_W-1:0]                             ret_data_i,
  output logic [NUM_PORTS-1:0]                          back_valid_o,
  input  logic [NUM_PORTS-1:0]                          back_ready_i,
  output logic [TAG_W-1:0]                              back_tag_o,
  output logic [DATA_W-1:0]                             back_data_o
);

  localparam int EXT_W  = ext_width(NUM_PORTS);
  localparam int OTAG_W = TAG_W + EXT_W;
  localparam int IDX_W  = (EXT_W > 0) ? EXT_W : 1;
  localparam int PAY_W  = OTAG_W + DATA_W;

  generate
    if (NUM_PORTS == 1) begin : g_wire
      assign fwd_valid_o  = req_valid_i[0];
      assign req_ready_o  = fwd_ready_i;
      assign fwd_tag_o    = req_tag_i;
      assign fwd_data_o   = req_data_i;
      assign back_valid_o = ret_valid_i;
      assign ret_ready_o  = back_ready_i[0];
      assign back_tag_o   = ret_tag_i;
      assign back_data_o  = ret_data_i;
    end else begin : g_mux
      logic [NUM_PORTS-1:0] gnt;
      logic [IDX_W-1:0]     gnt_idx;
      logic                 gnt_any;
      logic                 take;
      logic [TAG_W-1:0]     sel_tag;
      logic [DATA_W-1:0]    sel_data;
      logic [PAY_W-1:0]     pay_in;
      logic [PAY_W-1:0]     pay_out;

      tag_xbar_arb #(
        .NUM_PORTS (NUM_PORTS),
        .IDX_W     (IDX_W),
        .MODE      (ARB_MODE)
      ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_valid_i),
        .take    (take),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
      );

      assign req_ready_o = gnt & {NUM_PORTS{take}};

      always_comb begin
        sel_tag  = req_tag_i[gnt_idx*TAG_W +: TAG_W];
        sel_data = req_data_i[gnt_idx*DATA_W +: DATA_W];
        pay_in   = {sel_tag, gnt_idx[EXT_W-1:0], sel_data};
      end

      tag_xbar_pipe #(
        .WIDTH (PAY_W),
        .DEPTH (REQ_LAT)
      ) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (gnt_any),
        .in_ready    (take),
        .in_payload  (pay_in),
        .out_valid   (fwd_valid_o),
        .out_ready   (fwd_ready_i),
        .out_payload (pay_out)
      );

      assign fwd_tag_o  = pay_out[PAY_W-1:DATA_W];
      assign fwd_data_o = pay_out[DATA_W-1:0];

      tag_xbar_rsp #(
        .NUM_PORTS (NUM_PORTS),
        .TAG_W     (TAG_W),
        .EXT_W     (EXT_W),
        .DATA_W    (DATA_W)
      ) u_rsp (
        .clk          (clk),
        .rst_n        (rst_n),
        .ret_valid_i  (ret_valid_i),
        .ret_ready_o  (ret_ready_o),
        .ret_tag_i    (ret_tag_i),
        .ret_data_i   (ret_data_i),
        .back_valid_o (back_valid_o),
        .back_ready_i (back_ready_i),
        .back_tag_o   (back_tag_o),
        .back_data_o  (back_data_o)
      );
    end
  endgenerate

endmodule

// File: rtl/tag_xbar_chk.sv
module tag_xbar_chk #(
  parameter int NUM_PORTS = 4,
  parameter int TAG_W     = 8,
  parameter int DATA_W    = 16,
  parameter int OTAG_W    = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PORTS-1:0] req_valid_i,
  input logic [NUM_PORTS-1:0] req_ready_o,
  input logic                 fwd_valid_o,
  input logic                 fwd_ready_i,
  input logic [OTAG_W-1:0]    fwd_tag_o,
  input logic [DATA_W-1:0]    fwd_data_o,
  input logic                 ret_ready_o,
  input logic [NUM_PORTS-1:0] back_valid_o,
  input logic [NUM_PORTS-1:0] back_ready_i,
  input logic [TAG_W-1:0]     back_tag_o,
  input logic [DATA_W-1:0]    back_data_o
);

  a_r2_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(back_valid_o));

  generate
    if (NUM_PORTS > 1) begin : g_multi
      a_r3_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready_o));

      a_r3_grant_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready_o & ~req_valid_i) == '0);

      a_r7_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid_o && !fwd_ready_i) |=>
          (fwd_valid_o && $stable(fwd_tag_o) && $stable(fwd_data_o)));

      a_r8_back_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((back_valid_o != '0) && ((back_valid_o & back_ready_i) == '0)) |=>
          ($stable(back_valid_o) && $stable(back_tag_o) && $stable(back_data_o)));

      a_r8_busy_means_held: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_ready_o |-> (back_valid_o != '0));
    end
  endgenerate

endmodule

bind tag_xbar tag_xbar_chk #(
  .NUM_PORTS (NUM_PORTS),
  .TAG_W     (TAG_W),
  .DATA_W    (DATA_W),
  .OTAG_W    (OTAG_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .fwd_valid_o  (fwd_valid_o),
  .fwd_ready_i  (fwd_ready_i),
  .fwd_tag_o    (fwd_tag_o),
  .fwd_data_o   (fwd_data_o),
  .ret_ready_o  (ret_ready_o),
  .back_valid_o (back_valid_o),
  .back_ready_i (back_ready_i),
  .back_tag_o   (back_tag_o),
  .back_data_o  (back_data_o)
);

// File: tb/tag_xbar_test.sv
module tag_xbar_test;
  import tag_xbar_pkg::*;

  localparam int LAT_A = 2;

  logic clk;
  logic rst_n;
  int   vectors;
  int   miscompares;
  bit   finished;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- instance A: 4 ports, rotating, latency 2
  logic [3:0]  a_req_valid, a_req_ready;
  logic [31:0] a_req_tag;
  logic [63:0] a_req_data;
  logic        a_fwd_valid, a_fwd_ready;
  logic [9:0]  a_fwd_tag;
  logic [15:0] a_fwd_data;
  logic        a_ret_valid, a_ret_ready;
  logic [9:0]  a_ret_tag;
  logic [15:0] a_ret_data;
  logic [3:0]  a_back_valid, a_back_ready;
  logic [7:0]  a_back_tag;
  logic [15:0] a_back_data;

  tag_xbar #(.NUM_PORTS(4), .TAG_W(8), .DATA_W(16), .REQ_LAT(LAT_A), .ARB_MODE(ARB_ROTATE)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(a_req_valid), .req_ready_o(a_req_ready), .req_tag_i(a_req_tag), .req_data_i(a_req_data),
    .fwd_valid_o(a_fwd_valid), .fwd_ready_i(a_fwd_ready), .fwd_tag_o(a_fwd_tag), .fwd_data_o(a_fwd_data),
    .ret_valid_i(a_ret_valid), .ret_ready_o(a_ret_ready), .ret_tag_i(a_ret_tag), .ret_data_i(a_ret_data),
    .back_valid_o(a_back_valid), .back_ready_i(a_back_ready), .back_tag_o(a_back_tag), .back_data_o(a_back_data)
  );

  // ---------------- instance B: 3 ports, fixed priority, latency 1
  logic [2:0]  b_req_valid, b_req_ready;
  logic [23:0] b_req_tag;
  logic [47:0] b_req_data;
  logic        b_fwd_valid, b_fwd_ready;
  logic [9:0]  b_fwd_tag;
  logic [15:0] b_fwd_data;
  logic        b_ret_valid, b_ret_ready;
  logic [9:0]  b_ret_tag;
  logic [15:0] b_ret_data;
  logic [2:0]  b_back_valid, b_back_ready;
  logic [7:0]  b_back_tag;
  logic [15:0] b_back_data;

  tag_xbar #(.NUM_PORTS(3), .TAG_W(8), .DATA_W(16), .REQ_LAT(1), .ARB_MODE(ARB_FIXED)) uut_fixed (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(b_req_valid), .req_ready_o(b_req_ready), .req_tag_i(b_req_tag), .req_data_i(b_req_data),
    .fwd_valid_o(b_fwd_valid), .fwd_ready_i(b_fwd_ready), .fwd_tag_o(b_fwd_tag), .fwd_data_o(b_fwd_data),
    .ret_valid_i(b_ret_valid), .ret_ready_o(b_ret_ready), .ret_tag_i(b_ret_tag), .ret_data_i(b_ret_data),
    .back_valid_o(b_back_valid), .back_ready_i(b_back_ready), .back_tag_o(b_back_tag), .back_data_o(b_back_data)
  );

  // ---------------- instance C: single port
  logic [0:0]  c_req_valid, c_req_ready;
  logic [7:0]  c_req_tag;
  logic [15:0] c_req_data;
  logic        c_fwd_valid, c_fwd_ready;
  logic [7:0]  c_fwd_tag;
  logic [15:0] c_fwd_data;
  logic        c_ret_valid, c_ret_ready;
  logic [7:0]  c_ret_tag;
  logic [15:0] c_ret_data;
  logic [0:0]  c_back_valid, c_back_ready;
  logic [7:0]  c_back_tag;
  logic [15:0] c_back_data;

  tag_xbar #(.NUM_PORTS(1), .TAG_W(8), .DATA_W(16), .REQ_LAT(1), .ARB_MODE(ARB_ROTATE)) uut_single (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(c_req_valid), .req_ready_o(c_req_ready), .req_tag_i(c_req_tag), .req_data_i(c_req_data),
    .fwd_valid_o(c_fwd_valid), .fwd_ready_i(c_fwd_ready), .fwd_tag_o(c_fwd_tag), .fwd_data_o(c_fwd_data),
    .ret_valid_i(c_ret_valid), .ret_ready_o(c_ret_ready), .ret_tag_i(c_ret_tag), .ret_data_i(c_ret_data),
    .back_valid_o(c_back_valid), .back_ready_i(c_back_ready), .back_tag_o(c_back_tag), .back_data_o(c_back_data)
  );

  typedef struct {
    logic [7:0]  tag;
    logic [1:0]  idx;
    logic [15:0] data;
    int          cyc;
  } item_t;

  item_t req_q[$];
  item_t rsp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  // bench-side source and response state for instance A
  logic [3:0]  sv;
  logic [7:0]  stag [4];
  logic [15:0] sdat [4];
  logic        rv;
  logic [7:0]  rtag;
  logic [1:0]  ridx;
  logic [15:0] rdat;
  int          cursor;
  int          cyc;
  logic        prev_stall;
  logic [9:0]  prev_tag;
  logic [15:0] prev_data;

  initial begin
    vectors = 0; miscompares = 0; finished = 1'b0;
    rst_n = 1'b0;
    a_req_valid = '0; a_req_tag = '0; a_req_data = '0; a_fwd_ready = 1'b0;
    a_ret_valid = 1'b0; a_ret_tag = '0; a_ret_data = '0; a_back_ready = '0;
    b_req_valid = '0; b_req_tag = '0; b_req_data = '0; b_fwd_ready = 1'b1;
    b_ret_valid = 1'b0; b_ret_tag = '0; b_ret_data = '0; b_back_ready = '1;
    c_req_valid = '0; c_req_tag = '0; c_req_data = '0; c_fwd_ready = 1'b0;
    c_ret_valid = 1'b0; c_ret_tag = '0; c_ret_data = '0; c_back_ready = '0;
    sv = '0; rv = 1'b0; cursor = 0; cyc = 0; prev_stall = 1'b0;
    prev_tag = '0; prev_data = '0; rtag = '0; ridx = '0; rdat = '0;
    for (int p = 0; p < 4; p++) begin stag[p] = '0; sdat[p] = '0; end

    repeat (3) @(negedge clk);
    #1;
    check(a_fwd_valid == 1'b0, "R10", "fwd_valid in reset", 64'(a_fwd_valid), 0);
    check(a_back_valid == 4'b0, "R10", "back_valid in reset", 64'(a_back_valid), 0);
    check(b_fwd_valid == 1'b0, "R10", "fixed fwd_valid in reset", 64'(b_fwd_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // ---------------- phase A: random traffic against a behavioural model
    for (int k = 0; k < 1500; k++) begin
      bit free_flow;
      bit drain;
      int win;
      logic [3:0] gr;
      logic [3:0] exp_bv;
      bit exp_rr;
      @(negedge clk);
      cyc++;
      free_flow = (k < 600);
      drain     = (k >= 1400);
      for (int p = 0; p < 4; p++) begin
        if (!sv[p] && !drain && (k < 2 || ($urandom % 3) != 0)) begin
          sv[p] = 1'b1; stag[p] = 8'($urandom); sdat[p] = 16'($urandom);
        end
      end
      if (!rv && !drain && ($urandom % 2) == 1) begin
        rv = 1'b1; rtag = 8'($urandom); ridx = 2'($urandom); rdat = 16'($urandom);
      end
      a_fwd_ready  = (free_flow || drain) ? 1'b1 : 1'($urandom);
      a_back_ready = drain ? 4'hf : 4'($urandom);
      a_req_valid  = sv;
      for (int p = 0; p < 4; p++) begin
        a_req_tag[p*8 +: 8]   = stag[p];
        a_req_data[p*16 +: 16] = sdat[p];
      end
      a_ret_valid = rv;
      a_ret_tag   = {rtag, ridx};
      a_ret_data  = rdat;
      #1;

      // expected winner: first valid source from the cursor
      win = -1;
      for (int i = 0; i < 4; i++) begin
        if (win < 0 && sv[(cursor + i) % 4]) win = (cursor + i) % 4;
      end
      gr = a_req_ready;
      check($countones(gr) <= 1, "R3", "ready count", 64'(gr), 1);
      check((gr & ~sv) == 4'b0, "R3", "ready without valid", 64'(gr), 64'(sv));
      if (k == 0) check(gr == 4'b0001, "R10", "first grant to port 0", 64'(gr), 1);
      if (gr != 4'b0 && win >= 0)
        check(gr == 4'(1 << win), "R4", "rotating winner", 64'(gr), 64'(1 << win));
      if (free_flow && sv != 4'b0)
        check(gr != 4'b0, "R6", "grant while unstalled", 64'(gr), 64'(1 << win));

      // forwarded side
      if (prev_stall)
        check(a_fwd_valid && a_fwd_tag == prev_tag && a_fwd_data == prev_data, "R7",
              "held output", {a_fwd_valid, a_fwd_tag, a_fwd_data}, {1'b1, prev_tag, prev_data});
      if (free_flow) begin
        bit due;
        due = (req_q.size() > 0) && (req_q[0].cyc + LAT_A == cyc);
        check(a_fwd_valid == due, "R6", "output timing", 64'(a_fwd_valid), 64'(due));
      end
      if (a_fwd_valid) begin
        if (req_q.size() == 0) begin
          check(1'b0, "R6", "unexpected output", 64'(a_fwd_tag), 0);
        end else begin
          check(a_fwd_tag == {req_q[0].tag, req_q[0].idx}, "R1", "extended tag",
                64'(a_fwd_tag), 64'({req_q[0].tag, req_q[0].idx}));
          check(a_fwd_data == req_q[0].data, "R1", "forwarded data",
                64'(a_fwd_data), 64'(req_q[0].data));
          if (a_fwd_ready) void'(req_q.pop_front());
        end
      end
      prev_stall = a_fwd_valid && !a_fwd_ready;
      prev_tag   = a_fwd_tag;
      prev_data  = a_fwd_data;

      if (gr != 4'b0) begin
        int g;
        item_t it;
        g = 0;
        for (int p = 0; p < 4; p++) if (gr[p]) g = p;
        it.tag = stag[g]; it.idx = 2'(g); it.data = sdat[g]; it.cyc = cyc;
        req_q.push_back(it);
        sv[g]  = 1'b0;
        cursor = (g + 1) % 4;
      end

      // response side
      exp_bv = (rsp_q.size() > 0) ? 4'(1 << rsp_q[0].idx) : 4'b0;
      check(a_back_valid == exp_bv, "R8", "response presented", 64'(a_back_valid), 64'(exp_bv));
      if (rsp_q.size() > 0) begin
        check(a_back_tag == rsp_q[0].tag && a_back_data == rsp_q[0].data, "R2",
              "stripped response", {a_back_tag, a_back_data}, {rsp_q[0].tag, rsp_q[0].data});
      end
      exp_rr = (rsp_q.size() == 0) || a_back_ready[rsp_q[0].idx];
      check(a_ret_ready == exp_rr, "R8", "response input ready", 64'(a_ret_ready), 64'(exp_rr));
      if (rsp_q.size() > 0 && a_back_ready[rsp_q[0].idx]) void'(rsp_q.pop_front());
      if (rv && a_ret_ready) begin
        item_t it;
        it.tag = rtag; it.idx = ridx; it.data = rdat; it.cyc = cyc;
        rsp_q.push_back(it);
        rv = 1'b0;
      end
    end
    check(req_q.size() == 0, "R7", "requests left after drain", 64'(req_q.size()), 0);
    check(rsp_q.size() == 0 && !rv, "R8", "responses left after drain", 64'(rsp_q.size()), 0);
    @(negedge clk);
    a_req_valid = '0; a_ret_valid = 1'b0;

    // ---------------- phase B: fixed priority, three ports
    for (int p = 0; p < 3; p++) begin
      b_req_tag[p*8 +: 8]    = 8'(8'h10 + p);
      b_req_data[p*16 +: 16] = 16'(16'h0100 + p);
    end
    for (int t = 0; t < 8; t++) begin
      logic [2:0] pat;
      logic [2:0] expg;
      int w;
      case (t)
        0: pat = 3'b110; 1: pat = 3'b111; 2: pat = 3'b111; 3: pat = 3'b111;
        4: pat = 3'b101; 5: pat = 3'b100; 6: pat = 3'b011; default: pat = 3'b010;
      endcase
      w = 0;
      for (int p = 2; p >= 0; p--) if (pat[p]) w = p;
      expg = 3'(1 << w);
      @(negedge clk);
      b_req_valid = pat;
      #1;
      check(b_req_ready == expg, "R5", "lowest valid wins", 64'(b_req_ready), 64'(expg));
      @(negedge clk);
      b_req_valid = '0;
      #1;
      check(b_fwd_valid && b_fwd_tag == {8'(8'h10 + w), 2'(w)}, "R1", "three-port tag",
            {b_fwd_valid, b_fwd_tag}, {1'b1, 8'(8'h10 + w), 2'(w)});
    end

    @(negedge clk);
    b_ret_valid = 1'b1; b_ret_tag = {8'hA5, 2'd2}; b_ret_data = 16'hBEEF; b_back_ready = 3'b111;
    @(negedge clk);
    b_ret_valid = 1'b1; b_ret_tag = {8'h5A, 2'd3}; b_ret_data = 16'h1234;
    #1;
    check(b_back_valid == 3'b100 && b_back_tag == 8'hA5 && b_back_data == 16'hBEEF, "R2",
          "route to port 2", {b_back_valid, b_back_tag, b_back_data}, {3'b100, 8'hA5, 16'hBEEF});
    @(negedge clk);
    b_ret_valid = 1'b1; b_ret_tag = {8'h33, 2'd0}; b_ret_data = 16'h4444; b_back_ready = 3'b000;
    #1;
    check(b_back_valid == 3'b000 && b_ret_ready, "R2", "unknown index dropped",
          {b_back_valid, b_ret_ready}, {3'b000, 1'b1});
    @(negedge clk);
    b_ret_valid = 1'b0;
    #1;
    check(b_back_valid == 3'b001 && !b_ret_ready, "R8", "held while port busy",
          {b_back_valid, b_ret_ready}, {3'b001, 1'b0});
    @(negedge clk);
    #1;
    check(b_back_valid == 3'b001 && b_back_tag == 8'h33, "R8", "still held",
          {b_back_valid, b_back_tag}, {3'b001, 8'h33});
    @(negedge clk);
    b_back_ready = 3'b001;
    #1;
    check(b_ret_ready == 1'b1, "R8", "ready when leaving", 64'(b_ret_ready), 1);
    @(negedge clk);
    #1;
    check(b_back_valid == 3'b000, "R8", "released", 64'(b_back_valid), 0);

    // ---------------- phase C: single port wiring
    @(negedge clk);
    c_req_valid = 1'b1; c_req_tag = 8'h3C; c_req_data = 16'hCAFE; c_fwd_ready = 1'b0;
    c_ret_valid = 1'b1; c_ret_tag = 8'h77; c_ret_data = 16'h0F0F; c_back_ready = 1'b0;
    #1;
    check(c_fwd_valid && c_fwd_tag == 8'h3C && c_fwd_data == 16'hCAFE && !c_req_ready[0], "R9",
          "request wire", {c_fwd_valid, c_fwd_tag, c_req_ready}, {1'b1, 8'h3C, 1'b0});
    check(c_back_valid[0] && c_back_tag == 8'h77 && !c_ret_ready, "R9", "response wire",
          {c_back_valid, c_back_tag, c_ret_ready}, {1'b1, 8'h77, 1'b0});
    c_fwd_ready = 1'b1; c_back_ready = 1'b1;
    #1;
    check(c_req_ready[0] && c_ret_ready, "R9", "ready follows", {c_req_ready, c_ret_ready}, 2'b11);

    @(negedge clk);
    finish_run();
  end

endmodule